// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

A purely combinational unit that forms the second operand of a datapath stage by shifting or rotating a 32-bit value, and reports the shifter carry-out that a later flag-update stage would consume. Five operations are available: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right that feeds the incoming carry flag into the top bit.

The carry-out and the result have rules of their own at three places in the amount range: an amount of zero, an amount equal to the word width, and an amount larger than the word width. A caller supplies the operand, the operation code, an 8-bit amount and the current carry flag. Both outputs settle in the same cycle with no internal state, so the unit sits between a register-read stage and an ALU.

Top module: `opnd_shifter`

## Requirements
- R1: The operation code `kind_i` selects 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = one-bit rotate right through carry. The shift amount is the 8-bit value `amount_i`, so amounts range from 0 to 255.
- R2: For logical left, logical right, arithmetic right and rotate right, an amount of 0 gives `result_o` equal to the operand and `carry_o` equal to `carry_i`.
- R3: Logical left by n in 1..32 gives the operand shifted left with zero fill, and `carry_o` equal to operand bit 32-n. By exactly 32 the result is 0 and the carry is operand bit 0.
- R4: Logical right by n in 1..32 gives the operand shifted right with zero fill, and `carry_o` equal to operand bit n-1. By exactly 32 the result is 0 and the carry is operand bit 31.
- R5: Arithmetic right by n in 1..32 fills the vacated upper bits with operand bit 31, and `carry_o` equals operand bit n-1.
- R6: Logical left or logical right by more than 32 gives a result of 0 and a carry of 0.
- R7: Arithmetic right by more than 32 gives every result bit and the carry equal to operand bit 31.
- R8: Rotate right by a nonzero amount rotates by the amount modulo 32, and `carry_o` equals bit 31 of the result. An amount that is a multiple of 32 returns the operand unchanged with the carry equal to operand bit 31.
- R9: One-bit rotate through carry gives `{carry_i, operand[31:1]}` and `carry_o` equal to operand bit 0, whatever the amount.
- R10: Codes 5, 6 and 7 give a result of 0 and `carry_o` equal to `carry_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted or rotated |
| kind_i | input | 3 | Operation code |
| amount_i | input | 8 | Shift or rotate amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The assertions are immediate checks that are evaluated whenever the inputs change. They assume that every input carries a defined 0 or 1 value and that the amount is already limited to its 8-bit port, so the upper bits of a wider register field never reach the block. The stimulus drives only full, defined values on all four inputs. It sweeps the amounts around the zero, word-width and over-width boundaries, including 255 and multiples of 32, for every code from 0 to 7, with both carry values and with operands whose top and bottom bits differ.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/shf_amount_decode.sv
// Classifies the shift amount against the word width.
module shf_amount_decode #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic [AMT_W-1:0] amount_i,
  output logic             is_zero_o,
  output logic             is_full_o,
  output logic             is_over_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

  assign is_zero_o = (amount_i == '0);
  assign is_full_o = (amount_i == FULL);
  assign is_over_o = (amount_i > FULL);
  assign cnt_o     = amount_i[CNT_W-1:0];
endmodule

// File: rtl/shf_right_barrel.sv
// Logarithmic right shifter; each stage either fills or wraps.
module shf_right_barrel #(
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             fill_i,
  input  logic             rotate_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] stage [0:CNT_W];

  assign stage[0] = data_i;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [WIDTH-1:0] wrapped;
    logic [WIDTH-1:0] filled;
    assign wrapped = {stage[s][SH-1:0], stage[s][WIDTH-1:SH]};
    assign filled  = {{SH{fill_i}}, stage[s][WIDTH-1:SH]};
    assign stage[s+1] = !cnt_i[s] ? stage[s] : (rotate_i ? wrapped : filled);
  end

  assign data_o = stage[CNT_W];
endmodule

// File: rtl/shf_carry_pick.sv
// Selects the last bit shifted out for an amount of 1..WIDTH
// (an amount of WIDTH arrives as a count of zero).
module shf_carry_pick #(
  parameter int WIDTH = 32,
  parameter int CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             left_i,
  output logic             bit_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] idx;

  always_comb begin
    if (left_i) idx = (~cnt_i) + ONE;
    else        idx = cnt_i - ONE;
    bit_o = data_i[idx];
  end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opnd_shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0]  operand_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              carry_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_o
);
  localparam int CNT_W = $clog2(WIDTH);

  logic             is_zero, is_full, is_over;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] rev_in, left_rev, left_val, right_val;
  logic             sign, pick_l, pick_r, r_fill, r_rot;

  assign sign   = operand_i[WIDTH-1];
  assign r_fill = (kind_i == SH_ASR) & sign;
  assign r_rot  = (kind_i == SH_ROR);

  shf_amount_decode #(.WIDTH(WIDTH), .AMT_W(AMT_W), .CNT_W(CNT_W)) u_dec (
    .amount_i (amount_i),
    .is_zero_o(is_zero),
    .is_full_o(is_full),
    .is_over_o(is_over),
    .cnt_o    (cnt)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign rev_in[i]   = operand_i[WIDTH-1-i];
    assign left_val[i] = left_rev[WIDTH-1-i];
  end

  shf_right_barrel #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_left (
    .data_i  (rev_in),
    .cnt_i   (cnt),
    .fill_i  (1'b0),
    .rotate_i(1'b0),
    .data_o  (left_rev)
  );

  shf_right_barrel #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_right (
    .data_i  (operand_i),
    .cnt_i   (cnt),
    .fill_i  (r_fill),
    .rotate_i(r_rot),
    .data_o  (right_val)
  );

  shf_carry_pick #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_pick_l (
    .data_i(operand_i),
    .cnt_i (cnt),
    .left_i(1'b1),
    .bit_o (pick_l)
  );

  shf_carry_pick #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_pick_r (
    .data_i(operand_i),
    .cnt_i (cnt),
    .left_i(1'b0),
    .bit_o (pick_r)
  );

  always_comb begin
    result_o = '0;
    carry_o  = carry_i;
    case (kind_i)
      SH_LSL: begin
        if (is_zero) begin
          result_o = operand_i;
        end else if (is_over) begin
          carry_o = 1'b0;
        end else begin
          result_o = is_full ? '0 : left_val;
          carry_o  = pick_l;
        end
      end
      SH_LSR: begin
        if (is_zero) begin
          result_o = operand_i;
        end else if (is_over) begin
          carry_o = 1'b0;
        end else begin
          result_o = is_full ? '0 : right_val;
          carry_o  = pick_r;
        end
      end
      SH_ASR: begin
        if (is_zero) begin
          result_o = operand_i;
        end else if (is_over || is_full) begin
          result_o = {WIDTH{sign}};
          carry_o  = sign;
        end else begin
          result_o = right_val;
          carry_o  = pick_r;
        end
      end
      SH_ROR: begin
        if (is_zero) begin
          result_o = operand_i;
        end else begin
          result_o = right_val;
          carry_o  = right_val[WIDTH-1];
        end
      end
      SH_RRX: begin
        result_o = {carry_i, operand_i[WIDTH-1:1]};
        carry_o  = operand_i[0];
      end
      default: begin
        result_o = '0;
        carry_o  = carry_i;
      end
    endcase
  end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk
  import opnd_shifter_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input logic [WIDTH-1:0]  operand_i,
  input logic [KIND_W-1:0] kind_i,
  input logic [AMT_W-1:0]  amount_i,
  input logic              carry_i,
  input logic [WIDTH-1:0]  result_o,
  input logic              carry_o
);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

  always_comb begin
    // R2
    if (amount_i == '0 && kind_i <= 3'd3)
      p_zero_pass_r2: assert (result_o == operand_i && carry_o == carry_i);
    // R6
    if ((kind_i == 3'd0 || kind_i == 3'd1) && amount_i > FULL)
      p_over_clear_r6: assert (result_o == '0 && carry_o == 1'b0);
    // R7
    if (kind_i == 3'd2 && amount_i > FULL)
      p_asr_over_sign_r7: assert (result_o == {WIDTH{operand_i[WIDTH-1]}} && carry_o == operand_i[WIDTH-1]);
    // R5: the top bit of an arithmetic right shift keeps the sign
    if (kind_i == 3'd2)
      p_asr_top_r5: assert (result_o[WIDTH-1] == operand_i[WIDTH-1]);
    // R8
    if (kind_i == 3'd3 && amount_i != '0)
      p_ror_carry_r8: assert (carry_o == result_o[WIDTH-1]);
    // R8: a rotation moves bits without creating or losing any
    if (kind_i == 3'd3)
      p_ror_ones_r8: assert ($countones(result_o) == $countones(operand_i));
    // R9
    if (kind_i == 3'd4)
      p_rrx_r9: assert (carry_o == operand_i[0] && result_o[WIDTH-1] == carry_i
                        && result_o[WIDTH-2:0] == operand_i[WIDTH-1:1]);
    // R10
    if (kind_i > 3'd4)
      p_unused_code_r10: assert (result_o == '0 && carry_o == carry_i);
  end
endmodule

bind opnd_shifter opnd_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (.*);

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
  typedef struct {
    logic [31:0] res;
    logic        cy;
    string       tag;
    logic [31:0] op;
    logic [2:0]  kind;
    logic [7:0]  amt;
    logic        cin;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] operand;
  logic [2:0]  kind;
  logic [7:0]  amount;
  logic        carry_in;
  logic [31:0] result;
  logic        carry_out;

  item_t sb_q[$];
  int    checks   = 0;
  int    failures = 0;
  bit    drv_done = 1'b0;

  opnd_shifter u_opnd_shifter (
    .operand_i(operand),
    .kind_i   (kind),
    .amount_i (amount),
    .carry_i  (carry_in),
    .result_o (result),
    .carry_o  (carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference built from the requirements.
  function automatic void model(input logic [31:0] op, input logic [2:0] k,
                                input logic [7:0] n, input logic cin,
                                output logic [31:0] r, output logic c,
                                output string tag);
    logic [32:0] t33;
    logic signed [64:0] ext;
    logic [63:0] dbl;
    int m;
    r = 32'h0; c = cin; tag = "R10";
    case (k)
      3'd0: begin
        if (n == 0) begin r = op; c = cin; tag = "R2"; end
        else if (n > 32) begin r = 0; c = 0; tag = "R6"; end
        else begin t33 = {1'b0, op} << n; r = t33[31:0]; c = t33[32]; tag = "R3"; end
      end
      3'd1: begin
        if (n == 0) begin r = op; c = cin; tag = "R2"; end
        else if (n > 32) begin r = 0; c = 0; tag = "R6"; end
        else begin t33 = {op, 1'b0} >> n; r = t33[32:1]; c = t33[0]; tag = "R4"; end
      end
      3'd2: begin
        if (n == 0) begin r = op; c = cin; tag = "R2"; end
        else if (n > 32) begin r = {32{op[31]}}; c = op[31]; tag = "R7"; end
        else begin
          ext = {{32{op[31]}}, op, 1'b0};
          ext = ext >>> n;
          r = ext[32:1]; c = ext[0]; tag = "R5";
        end
      end
      3'd3: begin
        if (n == 0) begin r = op; c = cin; tag = "R2"; end
        else begin
          m = int'(n) % 32;
          dbl = {op, op} >> m;
          r = dbl[31:0]; c = r[31]; tag = "R8";
        end
      end
      3'd4: begin r = {cin, op[31:1]}; c = op[0]; tag = "R9"; end
      default: begin r = 0; c = cin; tag = "R10"; end
    endcase
    if (k <= 3'd4 && tag != "R2") tag = {tag, "/R1"};
  endfunction

  task automatic drive(input logic [31:0] op, input logic [2:0] k,
                       input logic [7:0] n, input logic cin);
    item_t it;
    @(negedge clk);
    operand = op; kind = k; amount = n; carry_in = cin;
    model(op, k, n, cin, it.res, it.cy, it.tag);
    it.op = op; it.kind = k; it.amt = n; it.cin = cin;
    sb_q.push_back(it);
  endtask

  // Monitor: inputs change at the falling edge, outputs are read at the next rising edge.
  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t e;
      e = sb_q.pop_front();
      checks++;
      if (result !== e.res || carry_out !== e.cy) begin
        failures++;
        $display("FAIL %s op=%h kind=%0d amt=%0d cin=%0b: got res=%h cy=%0b expected res=%h cy=%0b",
                 e.tag, e.op, e.kind, e.amt, e.cin, result, carry_out, e.res, e.cy);
      end
    end
  end

  initial begin
    logic [31:0] ops [4];
    logic [7:0]  amts [12];
    ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE;
    ops[2] = 32'hA5C3_0F96; ops[3] = 32'hFFFF_FFFF;
    amts[0] = 8'd0;   amts[1] = 8'd1;   amts[2] = 8'd2;   amts[3] = 8'd15;
    amts[4] = 8'd31;  amts[5] = 8'd32;  amts[6] = 8'd33;  amts[7] = 8'd64;
    amts[8] = 8'd96;  amts[9] = 8'd37;  amts[10] = 8'd255; amts[11] = 8'd128;
    operand = '0; kind = '0; amount = '0; carry_in = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // Idle state with all-zero inputs: R2 pass-through of zero.
    drive(32'h0, 3'd0, 8'd0, 1'b0);
    // R1..R10 sweep across codes, boundary amounts, operands and carry.
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 12; a++)
        for (int o = 0; o < 4; o++)
          for (int c = 0; c < 2; c++)
            drive(ops[o], 3'(k), amts[a], 1'(c));
    // R3 and R4 at the exact-width boundary with a single set bit.
    drive(32'h0000_0001, 3'd0, 8'd32, 1'b0);
    drive(32'h8000_0000, 3'd1, 8'd32, 1'b0);
    // R9: amount has no effect on one-bit rotate.
    drive(32'h0000_0003, 3'd4, 8'd200, 1'b1);
    @(negedge clk);
    @(negedge clk);
    drv_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!drv_done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!drv_done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule